// File: doc/BRIEF.md
# Paired-Register Lane Swizzle Mover

This block performs a four-lane swizzle move between two pairs of 64-bit registers. Each 64-bit word carries two 32-bit lanes. The low half of the first source word is lane X and its high half is lane Y. The low half of the second word is lane Z and its high half is lane W. The destination pair uses the same layout. A 12-bit immediate holds one 3-bit selector for each destination lane. Each selector does one of four things: it copies any source lane, it inserts constant 0 or constant 1, it skips the lane, or it marks where the destination subvector ends.

The issuing pipeline presents the following together with a one-cycle start strobe: both source words, the current destination contents, an in-place flag, an is-float flag and the two register indices. The block captures every source lane at that edge. In the next cycle it presents the complete destination pair, one write enable per destination register and a done pulse. An odd register index is reported as illegal, and in that case nothing is written. The block never issues a partial write.

Top module: `pair_swizzle_mover`

## Requirements
- R1: The selector for lane X is `imm_i[11:9]`, for Y `imm_i[8:6]`, for Z `imm_i[5:3]` and for W `imm_i[2:0]`. Lane X is `[31:0]` and lane Y is `[63:32]` of the first word. Lane Z is `[31:0]` and lane W is `[63:32]` of the second word. This layout holds for sources and destinations alike.
- R2: A selector `1nn` writes source lane nn into its destination lane, where nn = 0..3 stands for X, Y, Z, W. Any source lane may feed several destination lanes.
- R3: Selector `010` writes 0x00000000. Selector `011` writes 0x00000001 when `is_float_i` is 0.
- R4: Selector `011` writes 0x3F800000 when `is_float_i` is 1.
- R5: Selector `000` leaves its lane unwritten. An unwritten lane keeps the old destination value when `in_place_i` is 1 and reads zero when it is 0.
- R6: The first lane whose selector is `001` is unwritten, and so is every later lane, whatever their selectors hold. If no lane holds `001`, all four lanes follow their own selectors.
- R7: `wr_en_o[0]` covers the first destination word and `wr_en_o[1]` the second. For a legal move that is not in place, both bits are 1. For a legal in-place move, a bit is 1 exactly when at least one of that word's two lanes is written. Both bits are 0 whenever `done_o` is 0.
- R8: If `ra_idx_i` or `rt_idx_i` is odd at start, `illegal_o` and `done_o` are 1 in the next cycle, `wr_en_o` is 0 and the destination outputs equal the old destination contents.
- R9: `done_o` is 1 exactly in the cycle after each cycle in which `start_i` is sampled high. The result depends only on the inputs sampled at that start edge.
- R10: After reset, `done_o`, `illegal_o` and `wr_en_o` are 0 and both destination outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture the inputs and perform one move |
| in_place_i | input | 1 | Source and destination pair are the same registers |
| is_float_i | input | 1 | Constant 1 is single-precision 1.0 |
| imm_i | input | 12 | Four 3-bit lane selectors |
| ra_idx_i | input | 5 | Source pair register index |
| rt_idx_i | input | 5 | Destination pair register index |
| src_lo_i | input | 64 | First source word (lanes X, Y) |
| src_hi_i | input | 64 | Second source word (lanes Z, W) |
| old_lo_i | input | 64 | Current first destination word |
| old_hi_i | input | 64 | Current second destination word |
| dst_lo_o | output | 64 | New first destination word |
| dst_hi_o | output | 64 | New second destination word |
| wr_en_o | output | 2 | Write enable per destination word |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Odd register index seen |

## Verification
The bench builds the block with its default parameters: 32-bit lanes, 5-bit register indices and the single-precision encoding of 1.0. These values bring the full selector alphabet within reach across all four lanes. They also cover both constant forms and both odd-index paths. The directed scenarios use distinct lane patterns so that a misrouted lane or a swapped half shows up in the exact output word. The end-marker cases place the marker in the first lane and in a middle lane, with the move both in place and not in place.

// File: rtl/swz_pkg.sv
package swz_pkg;

  localparam int SEL_W     = 3;
  localparam int NUM_LANES = 4;
  localparam int IMM_W     = SEL_W * NUM_LANES;

  localparam logic [SEL_W-1:0] SEL_SKIP = 3'b000;
  localparam logic [SEL_W-1:0] SEL_END  = 3'b001;
  localparam logic [SEL_W-1:0] SEL_ZERO = 3'b010;
  localparam logic [SEL_W-1:0] SEL_ONE  = 3'b011;

  typedef enum logic [1:0] {
    K_SKIP = 2'd0,
    K_ZERO = 2'd1,
    K_ONE  = 2'd2,
    K_COPY = 2'd3
  } lane_kind_e;

  typedef struct packed {
    lane_kind_e  kind;
    logic [1:0]  src;
  } lane_ctl_t;

endpackage

// File: rtl/swz_field_decode.sv
module swz_field_decode
  import swz_pkg::*;
(
  input  logic [IMM_W-1:0]               imm_i,
  output lane_ctl_t [NUM_LANES-1:0]      ctl_o
);

  // ended[i] is set when some lane before i carried the end marker
  logic [NUM_LANES:0] ended;
  assign ended[0] = 1'b0;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    logic             is_end;
    lane_ctl_t        ctl;

    // lane 0 (X) occupies the most significant selector field
    assign sel           = imm_i[(NUM_LANES-1-i)*SEL_W +: SEL_W];
    assign is_end        = (sel == SEL_END);
    assign ended[i+1]    = ended[i] | is_end;

    always_comb begin
      ctl.src = sel[1:0];
      if (ended[i] || is_end) begin
        ctl.kind = K_SKIP;
      end else if (sel[SEL_W-1]) begin
        ctl.kind = K_COPY;
      end else begin
        case (sel)
          SEL_ZERO: ctl.kind = K_ZERO;
          SEL_ONE:  ctl.kind = K_ONE;
          default:  ctl.kind = K_SKIP;
        endcase
      end
    end

    assign ctl_o[i] = ctl;
  end

endmodule

// File: rtl/swz_lane_build.sv
module swz_lane_build
  import swz_pkg::*;
#(
  parameter int               LANE_W = 32,
  parameter logic [LANE_W-1:0] FP_ONE  = 32'h3F80_0000,
  parameter logic [LANE_W-1:0] INT_ONE = 32'h0000_0001
) (
  input  lane_ctl_t                           ctl_i,
  input  logic [NUM_LANES-1:0][LANE_W-1:0]    src_lanes_i,
  input  logic [LANE_W-1:0]                   old_lane_i,
  input  logic                                in_place_i,
  input  logic                                is_float_i,
  output logic [LANE_W-1:0]                   val_o,
  output logic                                written_o
);

  always_comb begin
    case (ctl_i.kind)
      K_COPY: begin
        val_o     = src_lanes_i[ctl_i.src];
        written_o = 1'b1;
      end
      K_ZERO: begin
        val_o     = '0;
        written_o = 1'b1;
      end
      K_ONE: begin
        val_o     = is_float_i ? FP_ONE : INT_ONE;
        written_o = 1'b1;
      end
      default: begin
        val_o     = in_place_i ? old_lane_i : '0;
        written_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
  parameter int DATA_W = 128,
  parameter int WE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [WE_W-1:0]   we_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] data_o,
  output logic [WE_W-1:0]   we_o,
  output logic              done_o,
  output logic              flag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      we_o   <= '0;
      done_o <= 1'b0;
      flag_o <= 1'b0;
    end else if (load_i) begin
      data_o <= data_i;
      we_o   <= we_i;
      done_o <= 1'b1;
      flag_o <= flag_i;
    end else begin
      we_o   <= '0;
      done_o <= 1'b0;
      flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pair_swizzle_mover.sv
module pair_swizzle_mover
  import swz_pkg::*;
#(
  parameter int                LANE_W    = 32,
  parameter int                REG_IDX_W = 5,
  parameter logic [LANE_W-1:0] FP_ONE    = 32'h3F80_0000,
  parameter logic [LANE_W-1:0] INT_ONE   = 32'h0000_0001,
  localparam int               WORD_W    = 2 * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 in_place_i,
  input  logic                 is_float_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic [REG_IDX_W-1:0] ra_idx_i,
  input  logic [REG_IDX_W-1:0] rt_idx_i,
  input  logic [WORD_W-1:0]    src_lo_i,
  input  logic [WORD_W-1:0]    src_hi_i,
  input  logic [WORD_W-1:0]    old_lo_i,
  input  logic [WORD_W-1:0]    old_hi_i,
  output logic [WORD_W-1:0]    dst_lo_o,
  output logic [WORD_W-1:0]    dst_hi_o,
  output logic [1:0]           wr_en_o,
  output logic                 done_o,
  output logic                 illegal_o
);

  localparam int PAIR_W = 2 * WORD_W;

  logic [NUM_LANES-1:0][LANE_W-1:0] src_lanes;
  logic [NUM_LANES-1:0][LANE_W-1:0] old_lanes;
  logic [NUM_LANES-1:0][LANE_W-1:0] new_lanes;
  logic [NUM_LANES-1:0]             lane_written;
  lane_ctl_t [NUM_LANES-1:0]        lane_ctl;

  assign src_lanes = {src_hi_i, src_lo_i};
  assign old_lanes = {old_hi_i, old_lo_i};

  swz_field_decode u_decode (
    .imm_i (imm_i),
    .ctl_o (lane_ctl)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_build
    swz_lane_build #(
      .LANE_W  (LANE_W),
      .FP_ONE  (FP_ONE),
      .INT_ONE (INT_ONE)
    ) u_lane (
      .ctl_i       (lane_ctl[i]),
      .src_lanes_i (src_lanes),
      .old_lane_i  (old_lanes[i]),
      .in_place_i  (in_place_i),
      .is_float_i  (is_float_i),
      .val_o       (new_lanes[i]),
      .written_o   (lane_written[i])
    );
  end

  logic              odd_index;
  logic [1:0]        word_touched;
  logic [1:0]        next_we;
  logic [PAIR_W-1:0] next_pair;

  assign odd_index    = ra_idx_i[0] | rt_idx_i[0];
  assign word_touched = {lane_written[3] | lane_written[2],
                         lane_written[1] | lane_written[0]};

  always_comb begin
    if (odd_index) begin
      next_we   = 2'b00;
      next_pair = {old_hi_i, old_lo_i};
    end else begin
      next_we   = in_place_i ? word_touched : 2'b11;
      next_pair = new_lanes;
    end
  end

  swz_out_stage #(
    .DATA_W (PAIR_W),
    .WE_W   (2)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .load_i (start_i),
    .data_i (next_pair),
    .we_i   (next_we),
    .flag_i (odd_index),
    .data_o ({dst_hi_o, dst_lo_o}),
    .we_o   (wr_en_o),
    .done_o (done_o),
    .flag_o (illegal_o)
  );

endmodule

// File: rtl/pair_swizzle_mover_chk.sv
module pair_swizzle_mover_chk #(
  parameter int IMM_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             in_place_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [1:0]       wr_en_o,
  input logic             done_o,
  input logic             illegal_o
);

  // R9
  done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i));

  // R9
  no_start_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_o);

  // R7
  we_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (wr_en_o == 2'b00));

  // R7
  we_full_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && !$past(in_place_i)) |-> (wr_en_o == 2'b11));

  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (done_o && wr_en_o == 2'b00));

  // R6
  lead_end_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(in_place_i) && $past(imm_i[IMM_W-1 -: 3]) == 3'b001)
      |-> (wr_en_o == 2'b00));

endmodule

bind pair_swizzle_mover pair_swizzle_mover_chk #(.IMM_W(12)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .in_place_i (in_place_i),
  .imm_i      (imm_i),
  .wr_en_o    (wr_en_o),
  .done_o     (done_o),
  .illegal_o  (illegal_o)
);

// File: tb/pair_swizzle_mover_tb.sv
module pair_swizzle_mover_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i, in_place_i, is_float_i;
  logic [11:0]  imm_i;
  logic [4:0]   ra_idx_i, rt_idx_i;
  logic [63:0]  src_lo_i, src_hi_i, old_lo_i, old_hi_i;
  logic [63:0]  dst_lo_o, dst_hi_o;
  logic [1:0]   wr_en_o;
  logic         done_o, illegal_o;

  always #2.5 clk = ~clk;

  pair_swizzle_mover dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .in_place_i(in_place_i),
    .is_float_i(is_float_i), .imm_i(imm_i), .ra_idx_i(ra_idx_i),
    .rt_idx_i(rt_idx_i), .src_lo_i(src_lo_i), .src_hi_i(src_hi_i),
    .old_lo_i(old_lo_i), .old_hi_i(old_hi_i), .dst_lo_o(dst_lo_o),
    .dst_hi_o(dst_hi_o), .wr_en_o(wr_en_o), .done_o(done_o),
    .illegal_o(illegal_o)
  );

  localparam logic [31:0] LX = 32'hA0A0_0000, LY = 32'hB1B1_1111;
  localparam logic [31:0] LZ = 32'hC2C2_2222, LW = 32'hD3D3_3333;
  localparam logic [31:0] O0 = 32'h0E0E_0E00, O1 = 32'h1E1E_1E11;
  localparam logic [31:0] O2 = 32'h2E2E_2E22, O3 = 32'h3E3E_3E33;
  localparam logic [2:0]  SK = 3'b000, EN = 3'b001, C0 = 3'b010, C1 = 3'b011;
  localparam logic [2:0]  PX = 3'b100, PY = 3'b101, PZ = 3'b110, PW = 3'b111;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  function automatic logic [11:0] mk(logic [2:0] x, logic [2:0] y,
                                     logic [2:0] z, logic [2:0] w);
    return {x, y, z, w};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one move at a falling edge, sample after the capture edge
  task automatic run_move(logic [11:0] imm, logic inpl, logic fl,
                          logic [4:0] ra, logic [4:0] rt);
    @(negedge clk);
    imm_i = imm; in_place_i = inpl; is_float_i = fl;
    ra_idx_i = ra; rt_idx_i = rt;
    src_lo_i = {LY, LX}; src_hi_i = {LW, LZ};
    old_lo_i = {O1, O0}; old_hi_i = {O3, O2};
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_move(string req, logic [63:0] lo, logic [63:0] hi,
                             logic [1:0] we);
    check(req, {dst_hi_o, dst_lo_o}, {hi, lo});
    check(req, {124'd0, wr_en_o, done_o, illegal_o}, {124'd0, we, 1'b1, 1'b0});
  endtask

  task automatic t_reset();
    check("R10", {dst_hi_o, dst_lo_o}, 128'd0);
    check("R10", {125'd0, wr_en_o, done_o}, 128'd0);
    check("R10", {127'd0, illegal_o}, 128'd0);
  endtask

  task automatic t_reverse();
    // R1 R2: WZYX reversal, not in place
    run_move(mk(PW, PZ, PY, PX), 1'b0, 1'b0, 5'd2, 5'd4);
    expect_move("R1", {LZ, LW}, {LX, LY}, 2'b11);
  endtask

  task automatic t_duplicate();
    run_move(mk(PY, PY, PX, PX), 1'b0, 1'b0, 5'd2, 5'd4);
    expect_move("R2", {LY, LY}, {LX, LX}, 2'b11);
  endtask

  task automatic t_int_consts();
    run_move(mk(C0, C1, PX, PY), 1'b0, 1'b0, 5'd2, 5'd4);
    expect_move("R3", {32'h1, 32'h0}, {LY, LX}, 2'b11);
  endtask

  task automatic t_float_const();
    run_move(mk(C0, C1, C1, PW), 1'b0, 1'b1, 5'd2, 5'd4);
    expect_move("R4", {32'h3F80_0000, 32'h0}, {LW, 32'h3F80_0000}, 2'b11);
  endtask

  task automatic t_skip_inplace();
    run_move(mk(PW, SK, PY, SK), 1'b1, 1'b0, 5'd6, 5'd6);
    expect_move("R5", {O1, LW}, {O3, LY}, 2'b11);
  endtask

  task automatic t_skip_fresh();
    run_move(mk(PW, SK, PY, SK), 1'b0, 1'b0, 5'd6, 5'd8);
    expect_move("R5", {32'h0, LW}, {32'h0, LY}, 2'b11);
  endtask

  task automatic t_end_mid_inplace();
    // R6 R7: marker in Z hides W; second word untouched
    run_move(mk(PY, PX, EN, PW), 1'b1, 1'b0, 5'd0, 5'd0);
    expect_move("R6", {LX, LY}, {O3, O2}, 2'b01);
  endtask

  task automatic t_end_mid_fresh();
    run_move(mk(PY, PX, EN, PW), 1'b0, 1'b0, 5'd0, 5'd2);
    expect_move("R6", {LX, LY}, 64'd0, 2'b11);
  endtask

  task automatic t_end_first();
    run_move(mk(EN, PX, PY, PZ), 1'b1, 1'b0, 5'd0, 5'd0);
    expect_move("R7", {O1, O0}, {O3, O2}, 2'b00);
  endtask

  task automatic t_inplace_hi_only();
    run_move(mk(SK, SK, SK, PX), 1'b1, 1'b0, 5'd4, 5'd4);
    expect_move("R7", {O1, O0}, {LX, O2}, 2'b10);
  endtask

  task automatic t_illegal();
    run_move(mk(PW, PZ, PY, PX), 1'b0, 1'b0, 5'd2, 5'd3);
    check("R8", {dst_hi_o, dst_lo_o}, {O3, O2, O1, O0});
    check("R8", {125'd0, wr_en_o, illegal_o}, {125'd0, 2'b00, 1'b1});
    run_move(mk(PW, PZ, PY, PX), 1'b0, 1'b0, 5'd1, 5'd4);
    check("R8", {126'd0, illegal_o, done_o}, {126'd0, 1'b1, 1'b1});
  endtask

  task automatic t_timing();
    run_move(mk(PZ, PW, PX, PY), 1'b0, 1'b0, 5'd2, 5'd4);
    // change sources after the capture edge: result must not move
    src_lo_i = '1; src_hi_i = '1;
    #0.5;
    check("R9", {dst_hi_o, dst_lo_o}, {LY, LX, LW, LZ});
    check("R9", {127'd0, done_o}, 128'd1);
    @(negedge clk);
    check("R9", {125'd0, wr_en_o, done_o}, 128'd0);
    check("R9", {dst_hi_o, dst_lo_o}, {LY, LX, LW, LZ});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; in_place_i = 1'b0; is_float_i = 1'b0;
    imm_i = '0; ra_idx_i = '0; rt_idx_i = '0;
    src_lo_i = '0; src_hi_i = '0; old_lo_i = '0; old_hi_i = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reverse();
    t_duplicate();
    t_int_consts();
    t_float_const();
    t_skip_inplace();
    t_skip_fresh();
    t_end_mid_inplace();
    t_end_mid_fresh();
    t_end_first();
    t_inplace_hi_only();
    t_illegal();
    t_timing();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule